// File: doc/BRIEF.md
# RAM-Backed Fixed Delay Line

This block delays a stream of data words by a fixed number of clock cycles, producing the same output a chain of flip-flop stages would. It keeps the words in a two-port memory, not in a register per stage. Each stored word stays at its address. Two address counters move through the memory in step. The write counter leaves each new word one slot behind the read counter, so a word is read back exactly when the counters have gone once around the memory.

The delay equals the memory depth, `2**ADDR_W` words. The block has no valid input, so it takes a new word on every clock edge. Its output is masked to zero until the memory holds a full set of words written since the last reset. A valid flag shows when the output carries delayed data.

Top module: `ram_delay_line`

## Requirements
- R1: While `rst_i` is sampled high at a rising edge, the block leaves that edge with `valid_o` low and `dout_o` all zeros.
- R2: When `valid_o` is high, after the k-th rising edge following reset release `dout_o` equals the `din_i` sampled at edge k-DEPTH+1, where DEPTH = 2**ADDR_W. This is the same as a flop chain of DEPTH stages.
- R3: `valid_o` goes high after exactly DEPTH rising edges with `rst_i` low following a reset, and then stays high until the next reset.
- R4: While `valid_o` is low, `dout_o` is all zeros, whatever the memory holds.
- R5: A reset in the middle of a stream restarts the fill. After the flag rises again, only words written after the reset appear at the output.
- R6: The read address starts at zero and the write address starts at DEPTH-1. Both advance by one on every non-reset edge and wrap modulo DEPTH, so the write address always trails the read address by one. A stream many times longer than DEPTH stays correct across the wraps.
- R7: Activity on `din_i` while `rst_i` is held high has no effect on `valid_o` or `dout_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| din_i | input | DATA_W | Word taken on every rising edge |
| dout_o | output | DATA_W | Word taken DEPTH edges earlier; zero while not valid |
| valid_o | output | 1 | High once the memory holds a full set of words written since reset |

## Verification
On every edge, the memory writes the newest word into the slot the read port just left, and it reads the oldest word from another slot. Pointer reset values or step rules that are off by one would make these two accesses collide or would shift the delay. The bench runs streams from a vector table and random streams through a DEPTH-stage reference chain and compares the output on every cycle. The check includes the cycle where the valid flag rises, the wrap of both counters, and a mid-stream reset.

// File: rtl/dlr_pkg.sv
package dlr_pkg;

    // Fill tracker state: counting edges after reset, or holding a full window.
    typedef enum logic [0:0] {
        FILL_COUNT = 1'b0,
        FILL_READY = 1'b1
    } fill_state_e;

endpackage

// File: rtl/dlr_ptr_ctr.sv
module dlr_ptr_ctr #(
    parameter int unsigned AW        = 4,
    parameter logic [AW-1:0] START   = '0
) (
    input  logic          clk_i,
    input  logic          rst_i,
    output logic [AW-1:0] ptr_o
);

    typedef struct packed {
        logic [AW-1:0] ptr;
    } ctr_t;

    ctr_t st_d, st_q;

    // Free-running modulo-2**AW address: wraps naturally at the width.
    always_comb begin
        st_d     = st_q;
        st_d.ptr = st_q.ptr + AW'(1);
        if (rst_i) begin
            st_d.ptr = START;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign ptr_o = st_q.ptr;

endmodule

// File: rtl/dlr_dpram.sv
module dlr_dpram #(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 8
) (
    input  logic          clk_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_q;

    // One write and one registered read per edge; a read of the slot being
    // written returns the previous contents.
    always_ff @(posedge clk_i) begin
        mem_q[waddr_i] <= wdata_i;
        rdata_q        <= mem_q[raddr_i];
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/dlr_fill_track.sv
module dlr_fill_track
    import dlr_pkg::*;
#(
    parameter int unsigned AW = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic valid_o
);

    localparam logic [AW-1:0] LAST = '1;

    typedef struct packed {
        fill_state_e   state;
        logic [AW-1:0] cnt;
    } fill_t;

    fill_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            FILL_COUNT: begin
                st_d.cnt = st_q.cnt + AW'(1);
                if (st_q.cnt == LAST) begin
                    st_d.state = FILL_READY;
                end
            end
            FILL_READY: begin
                st_d.cnt = st_q.cnt;
            end
            default: st_d.state = FILL_COUNT;
        endcase
        if (rst_i) begin
            st_d.state = FILL_COUNT;
            st_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign valid_o = (st_q.state == FILL_READY);

endmodule

// File: rtl/ram_delay_line.sv
module ram_delay_line #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              valid_o
);

    localparam logic [ADDR_W-1:0] RD_START = '0;
    localparam logic [ADDR_W-1:0] WR_START = '1;

    logic [ADDR_W-1:0] rd_ptr;
    logic [ADDR_W-1:0] wr_ptr;
    logic [DATA_W-1:0] ram_rdata;
    logic              fill_ok;

    dlr_ptr_ctr #(.AW(ADDR_W), .START(RD_START)) u_rd_ptr (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .ptr_o (rd_ptr)
    );

    dlr_ptr_ctr #(.AW(ADDR_W), .START(WR_START)) u_wr_ptr (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .ptr_o (wr_ptr)
    );

    dlr_dpram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
        .clk_i   (clk_i),
        .waddr_i (wr_ptr),
        .wdata_i (din_i),
        .raddr_i (rd_ptr),
        .rdata_o (ram_rdata)
    );

    dlr_fill_track #(.AW(ADDR_W)) u_fill (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .valid_o (fill_ok)
    );

    assign valid_o = fill_ok;
    assign dout_o  = fill_ok ? ram_rdata : '0;

endmodule

// File: rtl/ram_delay_line_chk.sv
module ram_delay_line_chk #(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] rd_ptr,
    input logic [AW-1:0] wr_ptr,
    input logic          valid,
    input logic [DW-1:0] dout
);

    // High once the previous edge was taken out of reset, so $past is meaningful.
    logic live_q;
    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b0;
        else     live_q <= 1'b1;
    end

    // R1: reset clears the flag and the output.
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!valid && dout == '0));

    // R6: write address trails read address by one slot.
    a_r6_ptr_gap: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (wr_ptr == rd_ptr - AW'(1)));

    // R6: read address steps by one each edge.
    a_r6_rd_step: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (rd_ptr == $past(rd_ptr) + AW'(1)));

    // R3: once raised, the flag stays up until reset.
    a_r3_valid_sticky: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(valid)) |-> valid);

    // R3: the flag rises as the read address completes a full lap.
    a_r3_rise_at_lap: assert property (@(posedge clk) disable iff (rst)
        (live_q && $rose(valid)) |-> (rd_ptr == '0));

    // R4: output is masked while not valid.
    a_r4_masked: assert property (@(posedge clk) disable iff (rst)
        !valid |-> (dout == '0));

endmodule

bind ram_delay_line ram_delay_line_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
    .clk    (clk_i),
    .rst    (rst_i),
    .rd_ptr (rd_ptr),
    .wr_ptr (wr_ptr),
    .valid  (valid_o),
    .dout   (dout_o)
);

// File: tb/tb_ram_delay_line.sv
module tb_ram_delay_line;

    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned DEPTH  = 1 << ADDR_W;
    localparam int unsigned NVEC   = 20;

    localparam logic [DATA_W-1:0] VEC [NVEC] = '{
        8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80,
        8'hFF, 8'h00, 8'hAA, 8'h55, 8'h5A, 8'hA5, 8'h3C, 8'hC3,
        8'h7E, 8'h81, 8'hE7, 8'h18
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout;
    logic              valid;

    int checks   = 0;
    int failures = 0;
    int edges    = 0;
    logic [DATA_W-1:0] model [DEPTH];

    always #5 clk = ~clk;

    ram_delay_line #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .din_i   (din),
        .dout_o  (dout),
        .valid_o (valid)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, clock, update model, check at next negedge.
    task automatic step(input logic [DATA_W-1:0] d, input string req);
        logic exp_v;
        din = d;
        @(posedge clk);
        for (int i = DEPTH - 1; i > 0; i--) model[i] = model[i-1];
        model[0] = d;
        edges++;
        @(negedge clk);
        exp_v = (edges >= DEPTH);
        check({req, " valid"}, DATA_W'(valid), DATA_W'(exp_v));
        check({req, " dout"}, dout, exp_v ? model[DEPTH-1] : '0);
    endtask

    task automatic do_reset(input int cycles);
        rst = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            din = DATA_W'($urandom);
            @(posedge clk);
            @(negedge clk);
            // R1 and R7: held reset keeps flag low and output zero.
            check("R1/R7 reset valid", DATA_W'(valid), '0);
            check("R1/R7 reset dout", dout, '0);
        end
        rst   = 1'b0;
        edges = 0;
    endtask

    initial begin
        fork
            begin
                #1000000;
                failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
            begin
                @(negedge clk);
                do_reset(3);
                // R2/R3/R4: vector table, fill and first outputs.
                for (int v = 0; v < NVEC; v++) step(VEC[v], "R2 table");
                // R6: long random stream across many wraps.
                for (int n = 0; n < 8 * DEPTH; n++) step(DATA_W'($urandom), "R6 wrap");
                // R5: reset mid-stream, then new distinct data only.
                do_reset(2);
                for (int n = 0; n < 3 * DEPTH; n++) step(DATA_W'(8'hC0 + n), "R5 refill");
                // R3: exact rise edge after a further reset.
                do_reset(1);
                for (int n = 0; n < DEPTH + 4; n++) step(DATA_W'(n), "R3 rise");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule